// File: doc/BRIEF.md
# Loadable Binary Counter with Six-State Truncation Modes

This block is a synchronous binary up counter. It has a clear input, a parallel-load input, a count enable and a carry-out. All flip-flops change on one common clock edge. The counter takes its feedback from a small piece of wrap control logic around it. A two-bit mode input selects one of four six-state cycles:

- two cycles run through 0 to 5, one by reloading zero and one by a feedback clear;
- one cycle runs through 10 to 15, by reloading on the carry;
- one cycle runs through 3 to 8, by reloading 3 at the top.

A terminal-state flag marks the last state of the selected cycle.

The external controls are applied in a fixed priority. Clear wins first, then load, then count. The internal feedback acts only on a normal count step. External software or logic can therefore place the counter anywhere, including outside the selected cycle. From such a state the counter counts up in plain binary until it enters the cycle.

The counter width, the cycle length and the start of the offset cycle are parameters. With the default values the block is a 4-bit counter with six-state cycles.

Top module: `mod_trunc_counter`

## Requirements
- R1: With `clr_n` low at a rising clock edge, `state` becomes 0 at that edge, whatever `load`, `count_en`, `load_val` and `mode` are. A low synchronous `rst_n` has the same effect.
- R2: With `clr_n` high and `load` high, `state` takes `load_val` at the edge, whatever `count_en` is. This external load also overrides any wrap feedback of the selected mode.
- R3: With `clr_n` high and `load` low, `count_en` high adds one to `state` (modulo 16) at each edge, and `count_en` low holds `state`.
- R4: `carry_out` is high in the same cycle exactly when `state` is 15 and `count_en` is high.
- R5: With `mode` = 2'b00, a count step from state 5 reloads 0, so the states repeat as 0,1,2,3,4,5.
- R6: With `mode` = 2'b01, the step that would produce 6 clears the counter instead. State 6 never appears, and the states repeat as 0,1,2,3,4,5.
- R7: With `mode` = 2'b10, the count step taken while `carry_out` is high reloads 10, so the states repeat as 10,11,12,13,14,15.
- R8: With `mode` = 2'b11, a count step from state 8 reloads 3, so the states repeat as 3,4,5,6,7,8.
- R9: `term_hit` is high exactly when `state` is the last state of the selected cycle: 5 for modes 2'b00 and 2'b01, 15 for 2'b10, 8 for 2'b11.
- R10: A state outside the selected cycle counts up in plain binary, wrapping from 15 to 0 if needed, until it reaches the cycle. Example: in mode 2'b00, state 9 steps through 10 to 15, then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low, sets state to 0 |
| clr_n | input | 1 | Synchronous clear, active low, highest priority control |
| load | input | 1 | Parallel load of `load_val` |
| count_en | input | 1 | Count enable |
| load_val | input | 4 | Parallel load value |
| mode | input | 2 | Cycle select: 00 reload-zero, 01 clear-at-six, 10 high cycle, 11 offset cycle |
| state | output | 4 | Counter state |
| carry_out | output | 1 | High when state is 15 and counting is enabled |
| term_hit | output | 1 | High in the terminal state of the selected cycle |

## Verification
The bench builds the block with its default parameters: 4-bit width, a six-state cycle, and 3 as the start of the offset cycle. At this width a full binary wrap takes only sixteen steps. That makes the plain-binary lead-in from reset into the 10-to-15 and 3-to-8 cycles reachable, as well as the 15-to-0 wrap from an out-of-cycle load, in a few dozen cycles. Each mode is run long enough to pass its lead-in and then go twice round its loop. The bench confirms exactly six distinct states in the expected order. In the clear-at-six mode it confirms that state 6 never shows.

// File: rtl/mtc_pkg.sv
// Package for the truncating counter.
// Holds the mode encoding shared by the wrap control and the top level.
// Assumes a two-bit mode select; all four codes are legal.
package mtc_pkg;

    typedef enum logic [1:0] {
        MODE_ZERO_RELOAD = 2'b00,  // 0..5, reload zero at the top
        MODE_SIX_CLEAR   = 2'b01,  // 0..5, clear on the step to six
        MODE_HIGH_RELOAD = 2'b10,  // top six states, reload on carry
        MODE_OFFSET      = 2'b11   // OFF_START.., reload at its top
    } mtc_mode_e;

endpackage

// File: rtl/mtc_core.sv
// Synchronous binary up counter core.
// Each bit toggles when all lower bits are one and counting is enabled,
// so every bit changes on the same edge.
// Priority: clear, then load, then count; otherwise the state is held.
// Assumes clr and ld are active high and already include any feedback.
module mtc_core #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ld,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         co
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] tog;
    logic [W-1:0] q_inc;

    // Toggle enables: bit i flips when all bits below it are one.
    generate
        for (genvar i = 0; i < W; i++) begin : g_tog
            if (i == 0) begin : g_lsb
                assign tog[i] = en;
            end else begin : g_upper
                assign tog[i] = en & (&q[i-1:0]);
            end
        end
    endgenerate

    // Incremented value, formed from the toggle enables.
    always_comb q_inc = q ^ tog;

    // Carry out: all ones with counting enabled.
    always_comb co = en & (&q);

    // State register with clear, load, count priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (ld) begin
            q <= d;
        end else begin
            q <= q_inc;
        end
    end

    assert_clear_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0));

    assert_load_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && ld) |=> (q == $past(d)));

    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld && en) |=> (q == $past(q) + ONE));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld && !en) |=> $stable(q));

    assert_carry_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (co && !clr && !ld) |=> (q == '0));

endmodule

// File: rtl/mtc_wrap_ctl.sv
// Wrap control for the truncating counter.
// Decodes the terminal state of the selected mode and produces either a
// feedback clear or a feedback load, with the restart value for that load.
// Feedback acts only on a plain count step: an external load suppresses it.
// Assumes SPAN <= 2**W and OFF_START + SPAN <= 2**W.
module mtc_wrap_ctl
    import mtc_pkg::*;
#(
    parameter int W         = 4,
    parameter int SPAN      = 6,
    parameter int OFF_START = 3
) (
    input  mtc_mode_e    mode,
    input  logic [W-1:0] q,
    input  logic         en,
    input  logic         ld,
    input  logic         co,
    output logic         fb_clr,
    output logic         fb_ld,
    output logic [W-1:0] fb_val,
    output logic         term
);

    localparam logic [W-1:0] ONE     = W'(1);
    localparam logic [W-1:0] LOW_TOP = W'(SPAN - 1);
    localparam logic [W-1:0] SIX_AT  = W'(SPAN);
    localparam logic [W-1:0] HI_BASE = W'((1 << W) - SPAN);
    localparam logic [W-1:0] HI_TOP  = '1;
    localparam logic [W-1:0] OF_BASE = W'(OFF_START);
    localparam logic [W-1:0] OF_TOP  = W'(OFF_START + SPAN - 1);

    logic         step;
    logic [W-1:0] q_next;

    // A plain count step is the only event feedback may act on.
    always_comb step = en & ~ld;

    // Value the counter would reach on this step.
    always_comb q_next = q + ONE;

    // Per-mode terminal decode, feedback selection and restart value.
    always_comb begin
        fb_clr = 1'b0;
        fb_ld  = 1'b0;
        fb_val = '0;
        term   = 1'b0;
        unique case (mode)
            MODE_ZERO_RELOAD: begin
                term  = (q == LOW_TOP);
                fb_ld = step & term;
            end
            MODE_SIX_CLEAR: begin
                term   = (q == LOW_TOP);
                fb_clr = step & (q_next == SIX_AT);
            end
            MODE_HIGH_RELOAD: begin
                term   = (q == HI_TOP);
                fb_ld  = co & ~ld;
                fb_val = HI_BASE;
            end
            MODE_OFFSET: begin
                term   = (q == OF_TOP);
                fb_ld  = step & term;
                fb_val = OF_BASE;
            end
            default: ;
        endcase
    end

    // Feedback never requests clear and load together.
    always_comb begin
        assert_fb_exclusive_R6: assert (!(fb_clr && fb_ld));
    end

endmodule

// File: rtl/mod_trunc_counter.sv
// Top level: loadable binary counter with six-state truncation modes.
// Merges the external controls with the mode feedback and drives the core.
// External clear and load are taken as they come; feedback is folded in
// below them, so external control always wins over the wrap.
// Assumes inputs synchronous to clk.
module mod_trunc_counter #(
    parameter int W         = 4,
    parameter int SPAN      = 6,
    parameter int OFF_START = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_n,
    input  logic         load,
    input  logic         count_en,
    input  logic [W-1:0] load_val,
    input  logic [1:0]   mode,
    output logic [W-1:0] state,
    output logic         carry_out,
    output logic         term_hit
);

    import mtc_pkg::*;

    localparam logic [W-1:0] LOW_TOP = W'(SPAN - 1);
    localparam logic [W-1:0] HI_BASE = W'((1 << W) - SPAN);
    localparam logic [W-1:0] HI_TOP  = '1;
    localparam logic [W-1:0] OF_BASE = W'(OFF_START);
    localparam logic [W-1:0] OF_TOP  = W'(OFF_START + SPAN - 1);

    mtc_mode_e    mode_e;
    logic         fb_clr;
    logic         fb_ld;
    logic [W-1:0] fb_val;
    logic         core_clr;
    logic         core_ld;
    logic [W-1:0] core_d;

    // Mode select as the shared enum.
    always_comb mode_e = mtc_mode_e'(mode);

    // Merge external controls over feedback.
    always_comb begin
        core_clr = ~clr_n | fb_clr;
        core_ld  = load | fb_ld;
        core_d   = load ? load_val : fb_val;
    end

    mtc_wrap_ctl #(
        .W         (W),
        .SPAN      (SPAN),
        .OFF_START (OFF_START)
    ) u_wrap (
        .mode   (mode_e),
        .q      (state),
        .en     (count_en),
        .ld     (load),
        .co     (carry_out),
        .fb_clr (fb_clr),
        .fb_ld  (fb_ld),
        .fb_val (fb_val),
        .term   (term_hit)
    );

    mtc_core #(
        .W (W)
    ) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (core_clr),
        .ld    (core_ld),
        .en    (count_en),
        .d     (core_d),
        .q     (state),
        .co    (carry_out)
    );

    assert_zero_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && clr_n && !load && count_en && state == LOW_TOP)
        |=> (state == '0));

    assert_six_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && clr_n && !load && count_en && state == LOW_TOP)
        |=> (state == '0));

    assert_high_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && clr_n && !load && carry_out)
        |=> (state == HI_BASE));

    assert_offset_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11 && clr_n && !load && count_en && state == OF_TOP)
        |=> (state == OF_BASE));

    assert_term_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (term_hit && clr_n && !load && count_en && mode == 2'b10)
        |=> (state == HI_BASE));

    assert_term_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (term_hit && clr_n && !load && !count_en) |=> term_hit);

    assert_outside_counts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && clr_n && !load && count_en && state > LOW_TOP && state != HI_TOP)
        |=> (state == $past(state) + W'(1)));

endmodule

// File: tb/mod_trunc_counter_tb.sv
module mod_trunc_counter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 20000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       clr_n;
    logic       load;
    logic       count_en;
    logic [3:0] load_val;
    logic [1:0] mode;
    logic [3:0] state;
    logic       carry_out;
    logic       term_hit;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    mod_trunc_counter u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_n     (clr_n),
        .load      (load),
        .count_en  (count_en),
        .load_val  (load_val),
        .mode      (mode),
        .state     (state),
        .carry_out (carry_out),
        .term_hit  (term_hit)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Record one comparison and report a miscompare.
    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance one edge and settle away from it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic c, input logic l, input logic e,
                         input logic [3:0] d, input logic [1:0] m);
        clr_n = c; load = l; count_en = e; load_val = d; mode = m;
    endtask

    // Expected next state for a plain count step in a given mode.
    function automatic int next_exp(input int m, input int e);
        case (m)
            0, 1: return (e == 5) ? 0 : (e + 1) % 16;
            2:    return (e == 15) ? 10 : e + 1;
            default: return (e == 8) ? 3 : (e + 1) % 16;
        endcase
    endfunction

    function automatic int term_of(input int m);
        case (m)
            0, 1: return 5;
            2:    return 15;
            default: return 8;
        endcase
    endfunction

    task automatic t_reset();
        drive(1, 0, 1, 4'd9, 2'b00);
        rst_n = 1'b0;
        tick(); tick();
        check("R1 reset state", state, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_clear_prio();
        drive(1, 1, 0, 4'd7, 2'b00);
        tick();
        drive(0, 1, 1, 4'd11, 2'b00);
        tick();
        check("R1 clear over load and count", state, 0);
    endtask

    task automatic t_load_prio();
        drive(1, 1, 0, 4'd9, 2'b00);
        tick();
        check("R2 load with count off", state, 9);
        drive(1, 1, 1, 4'd12, 2'b00);
        tick();
        check("R2 load ignores count", state, 12);
    endtask

    task automatic t_count_hold();
        drive(1, 1, 0, 4'd2, 2'b11);
        tick();
        drive(1, 0, 0, 4'd0, 2'b11);
        tick(); tick(); tick();
        check("R3 hold with count off", state, 2);
        drive(1, 0, 1, 4'd0, 2'b11);
        tick();
        check("R3 count step", state, 3);
        tick();
        check("R3 second count step", state, 4);
    endtask

    task automatic t_carry();
        drive(1, 1, 0, 4'd15, 2'b00);
        tick();
        drive(1, 0, 0, 4'd0, 2'b00);
        #1;
        check("R4 no carry when count off", carry_out, 0);
        count_en = 1'b1;
        #1;
        check("R4 carry at fifteen", carry_out, 1);
        tick();
        check("R4 wrap to zero", state, 0);
        check("R4 carry drops", carry_out, 0);
    endtask

    // Run one mode from a clear; check order, six distinct states, no six in B.
    task automatic t_mode_seq(input int m, input string req);
        int e = 0;
        int seen = 0;
        int n_seen = 0;
        bit bad_six = 1'b0;
        drive(0, 0, 0, 4'd0, 2'(m));
        tick();
        drive(1, 0, 1, 4'd0, 2'(m));
        for (int i = 0; i < 30; i++) begin
            check({req, " carry"}, carry_out, (e == 15) ? 1 : 0);
            check("R9 terminal flag", term_hit, (e == term_of(m)) ? 1 : 0);
            tick();
            e = next_exp(m, e);
            check({req, " sequence"}, state, e);
            if (m == 1 && state == 4'd6) bad_six = 1'b1;
            if (i >= 18) seen = seen | (1 << state);
        end
        for (int b = 0; b < 16; b++) if (seen[b]) n_seen++;
        check({req, " distinct states"}, n_seen, 6);
        if (m == 1) check("R6 six never visible", bad_six, 0);
    endtask

    task automatic t_ext_load_wins();
        drive(1, 1, 0, 4'd5, 2'b00);
        tick();
        drive(1, 1, 1, 4'd9, 2'b00);
        tick();
        check("R2 external load beats wrap", state, 9);
        drive(1, 0, 1, 4'd0, 2'b00);
        for (int i = 10; i <= 15; i++) begin
            tick();
            check("R10 outside state counts up", state, i);
        end
        tick();
        check("R10 wraps into cycle", state, 0);
    endtask

    initial begin
        drive(1, 0, 0, 4'd0, 2'b00);
        rst_n = 1'b0;
        t_reset();
        t_clear_prio();
        t_load_prio();
        t_count_hold();
        t_carry();
        t_mode_seq(0, "R5");
        t_mode_seq(1, "R6");
        t_mode_seq(2, "R7");
        t_mode_seq(3, "R8");
        t_ext_load_wins();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", MAX_CYCLES);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule